// File: doc/BRIEF.md
# DDR two-word burst SRAM

A synthesizable behavioural model of a synchronous pipelined SRAM with a double-data-rate, two-word-burst interface. It runs from one fast clock whose every edge stands for one edge of the main input clock pair. An internal phase bit marks which fast-clock edges play the role of the main clock's rising edge (phase 0) and which play its complement (phase 1). After reset the first fast-clock edge is a main-clock rise, and the two phases alternate from then on.

Commands are sampled only on main-clock rises. A load strobe starts a transaction, and a select chooses read or write. Every address names a pair of data words that always move together as a burst of two. Write data arrives one word per half-cycle, each word with its own active-low byte enables. Read data comes back as two consecutive half-cycle words. A mode input sets the latency to one main cycle or one and a half. The shared data bus is represented by separate in and out vectors plus an output enable. Two echo outputs run in step with the launch phases so that a receiver can capture the data.

A parameter selects the burst variant. In the narrow variant each address owns its own pair of words and bursts always start at word 0. In the wide variant the address LSB picks the starting word of a shared pair, and the burst wraps to the other word.

Top module: `ddrb_sram`

## Requirements
- R1: A command is accepted only on a main-clock rise (phase 0) with `ld_n` low, and only if no command was accepted on the previous main-clock rise. When `ld_n` is high, or on a phase-1 edge, `rw`, `addr` and the data inputs have no effect.
- R2: For a write accepted at main-rise edge E, the first burst word is taken from `dq_in` at edge E+2 and the second at edge E+3.
- R3: `bwe_n[b]` is active low and sampled with each data word. Byte b (bits b*BYTE_W and up) is written only when `bwe_n[b]` is 0; disabled bytes keep their contents.
- R4: Narrow variant (`WIDE_BURST`=0): address a holds words a*2 (first) and a*2+1 (second), and a burst always starts at the first.
- R5: Wide variant (`WIDE_BURST`=1): address a starts at word a and continues to word a XOR 1. A burst that starts on an odd word therefore wraps to the even word of the same pair.
- R6: With `dll_en`=0, a read accepted at edge E presents its first word on `dq_out` after edge E+2 and its second word after edge E+3.
- R7: With `dll_en`=1, the same read is half a cycle later: first word after edge E+3, second word after edge E+4.
- R8: `dq_oe` is high exactly during the two read data slots and low at all other times, including throughout writes.
- R9: After reset, `cq` is high in the slots that follow a main-clock rise and low in the others, and `cq_n` is always its complement. A first word launched with `dll_en`=0 coincides with `cq` high; with `dll_en`=1 it coincides with `cq_n` high.
- R10: Reset (synchronous, active low) drops any pending command and holds `dq_oe`=0, `cq`=0 and `cq_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each edge is one main-clock half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe that starts a transaction |
| rw | input | 1 | Operation select: 1 read, 0 write |
| addr | input | ADDR_W | Transaction address |
| dll_en | input | 1 | Latency mode: 0 one cycle, 1 one and a half cycles |
| dq_in | input | DATA_W | Write data word, one per half-cycle |
| bwe_n | input | DATA_W/BYTE_W | Active-low byte write enables for the current word |
| dq_out | output | DATA_W | Read data word |
| dq_oe | output | 1 | Drive enable for the shared data bus |
| cq | output | 1 | Echo clock, high after main-clock rises |
| cq_n | output | 1 | Complement echo clock |

## Verification
The bench runs a narrow and a wide instance side by side. It sweeps every address under full, partial and mixed byte masks and in both latency modes. Expected words come from an arithmetic word-index model in the bench. A design that gets the wide start word or its wrap wrong returns the two words swapped, or returns a neighbour's data. A design with a latency off by one half-cycle returns data one slot early or late, or misaligned with the echo phase. Further runs place a strobe on the ignored main-clock rise inside a burst, place strobes on phase-1 edges, present no-op data with its byte enables asserted, and reset in the middle of a read. A design that acts on any of these drives the bus when it should not, or corrupts stored words.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
   // command delay line length, in fast-clock slots
   localparam int PIPE_DEPTH = 4;

   // which burst word, if any, is launched on the next slot
   typedef enum logic [1:0] {
      RS_NONE   = 2'd0,
      RS_FIRST  = 2'd1,
      RS_SECOND = 2'd2
   } rd_slot_e;
endpackage

// File: rtl/ddrb_cmd_pipe.sv
module ddrb_cmd_pipe import ddrb_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter bit WIDE_BURST = 1'b0,
   parameter int WA_W       = ADDR_W + 1
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               ld_n,
   input  logic                               rw,
   input  logic [ADDR_W-1:0]                  addr,
   output logic                               ph,
   output logic [PIPE_DEPTH:2]                v_o,
   output logic [PIPE_DEPTH:2]                rd_o,
   output logic [PIPE_DEPTH:2][WA_W-1:0]      wa_o
);
   logic [WA_W-1:0]                 first_wa;
   logic                            accept;
   logic [PIPE_DEPTH:1]             v_q;
   logic [PIPE_DEPTH:1]             rd_q;
   logic [PIPE_DEPTH:1][WA_W-1:0]   wa_q;

   // word index of the first burst word
   generate
      if (WIDE_BURST) begin : g_wide
         assign first_wa = addr;
      end else begin : g_narrow
         assign first_wa = {addr, 1'b0};
      end
   endgenerate

   // main-clock rise only, and never on the rise right after an accept
   assign accept = !ph && !ld_n && !v_q[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph   <= 1'b0;
         v_q  <= '0;
         rd_q <= '0;
         wa_q <= '0;
      end else begin
         ph      <= ~ph;
         v_q[1]  <= accept;
         rd_q[1] <= accept & rw;
         wa_q[1] <= first_wa;
         for (int d = 2; d <= PIPE_DEPTH; d++) begin
            v_q[d]  <= v_q[d-1];
            rd_q[d] <= rd_q[d-1];
            wa_q[d] <= wa_q[d-1];
         end
      end
   end

   assign v_o  = v_q[PIPE_DEPTH:2];
   assign rd_o = rd_q[PIPE_DEPTH:2];
   assign wa_o = wa_q[PIPE_DEPTH:2];

   // R1
   single_slot_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[1] |=> !v_q[1]);

   // R1
   alternate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[1] |-> !v_q[3]);
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
   parameter int WA_W   = 9,
   parameter int DATA_W = 18,
   parameter int BYTE_W = 9,
   localparam int NBYTE = DATA_W / BYTE_W,
   localparam int NWORD = 2 ** WA_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [WA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NBYTE-1:0]  wbe_n,
   input  logic [WA_W-1:0]   raddr,
   output logic [DATA_W-1:0] rdata
);
   // contents are left undefined until written
   logic [DATA_W-1:0] mem [NWORD];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < NBYTE; b++) begin
            if (!wbe_n[b]) begin
               mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ddrb_out.sv
module ddrb_out #(
   parameter int DATA_W = 18
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph,
   input  logic              launch,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              cq,
   output logic              cq_n
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_out <= '0;
         dq_oe  <= 1'b0;
         cq     <= 1'b0;
         cq_n   <= 1'b1;
      end else begin
         dq_out <= launch ? rdata : '0;
         dq_oe  <= launch;
         cq     <= !ph;
         cq_n   <= ph;
      end
   end

   // R8
   burst_of_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |=> !dq_oe);

   // R9
   echo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cq == !$past(cq)));

   // R9
   echo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cq != cq_n);
endmodule

// File: rtl/ddrb_sram.sv
module ddrb_sram import ddrb_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 18,
   parameter int BYTE_W     = 9,
   parameter bit WIDE_BURST = 1'b0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_n,
   input  logic                       rw,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       dll_en,
   input  logic [DATA_W-1:0]          dq_in,
   input  logic [DATA_W/BYTE_W-1:0]   bwe_n,
   output logic [DATA_W-1:0]          dq_out,
   output logic                       dq_oe,
   output logic                       cq,
   output logic                       cq_n
);
   localparam int NBYTE = DATA_W / BYTE_W;
   localparam int WA_W  = WIDE_BURST ? ADDR_W : ADDR_W + 1;

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_bytes
         $error("DATA_W must be a multiple of BYTE_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic                           ph;
   logic [PIPE_DEPTH:2]            pv;
   logic [PIPE_DEPTH:2]            prd;
   logic [PIPE_DEPTH:2][WA_W-1:0]  pwa;

   logic              wr_first, wr_second, we, launch;
   logic [WA_W-1:0]   waddr, raddr;
   logic [DATA_W-1:0] rdata;
   rd_slot_e          slot;
   logic [WA_W-1:0]   base_first, base_second;

   // the other word of the same pair (wraps from word 1 to word 0)
   function automatic logic [WA_W-1:0] mate(input logic [WA_W-1:0] w);
      return {w[WA_W-1:1], ~w[0]};
   endfunction

   ddrb_cmd_pipe #(
      .ADDR_W     (ADDR_W),
      .WIDE_BURST (WIDE_BURST),
      .WA_W       (WA_W)
   ) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_n  (ld_n),
      .rw    (rw),
      .addr  (addr),
      .ph    (ph),
      .v_o   (pv),
      .rd_o  (prd),
      .wa_o  (pwa)
   );

   // write words land two and three slots after the command
   assign wr_first  = pv[2] && !prd[2];
   assign wr_second = pv[3] && !prd[3];
   assign we        = wr_first || wr_second;
   assign waddr     = wr_first ? pwa[2] : mate(pwa[3]);

   // read launch slot depends on the latency mode
   always_comb begin
      slot        = RS_NONE;
      base_first  = pwa[2];
      base_second = pwa[3];
      if (!dll_en) begin
         base_first  = pwa[2];
         base_second = pwa[3];
         if (pv[2] && prd[2])      slot = RS_FIRST;
         else if (pv[3] && prd[3]) slot = RS_SECOND;
      end else begin
         base_first  = pwa[3];
         base_second = pwa[4];
         if (pv[3] && prd[3])      slot = RS_FIRST;
         else if (pv[4] && prd[4]) slot = RS_SECOND;
      end
   end

   always_comb begin
      case (slot)
         RS_FIRST:  raddr = base_first;
         RS_SECOND: raddr = mate(base_second);
         default:   raddr = base_first;
      endcase
   end

   assign launch = (slot != RS_NONE);

   ddrb_array #(
      .WA_W   (WA_W),
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_array (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (dq_in),
      .wbe_n (bwe_n),
      .raddr (raddr),
      .rdata (rdata)
   );

   ddrb_out #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .ph     (ph),
      .launch (launch),
      .rdata  (rdata),
      .dq_out (dq_out),
      .dq_oe  (dq_oe),
      .cq     (cq),
      .cq_n   (cq_n)
   );

   // R6
   lat_one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dq_oe) && !dll_en) |-> cq);

   // R7
   lat_half_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dq_oe) && dll_en) |-> cq_n);

   // R2
   write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_first |=> (we && !dq_oe));
endmodule

// File: tb/ddrb_sram_test.sv
module ddrb_sram_test;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int BW = 8;
   localparam int NB = DW / BW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, ld_n, rw, dll_en;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic [NB-1:0] bwe_n;
   logic [DW-1:0] n_dq, w_dq;
   logic          n_oe, w_oe, n_cq, w_cq, n_cqn, w_cqn;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   logic [DW-1:0] mn [16];
   logic [DW-1:0] mw [8];

   ddrb_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .WIDE_BURST(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr), .dll_en(dll_en),
      .dq_in(din), .bwe_n(bwe_n), .dq_out(n_dq), .dq_oe(n_oe), .cq(n_cq), .cq_n(n_cqn));

   ddrb_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .WIDE_BURST(1'b1)) uut_w (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr), .dll_en(dll_en),
      .dq_in(din), .bwe_n(bwe_n), .dq_out(w_dq), .dq_oe(w_oe), .cq(w_cq), .cq_n(w_cqn));

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                         input logic [NB-1:0] be_n);
      logic [DW-1:0] r = old;
      for (int b = 0; b < NB; b++)
         if (!be_n[b]) r[b*BW +: BW] = nw[b*BW +: BW];
      return r;
   endfunction

   function automatic logic [DW-1:0] pat(input int a, input int k, input int s);
      return DW'(16'hA55A ^ (a * 16'h0123) ^ (k * 16'h3C07) ^ (s * 16'h1111));
   endfunction

   task automatic chk_oe_off(input string req);
      chk(!n_oe, req, DW'(n_oe), 0);
      chk(!w_oe, req, DW'(w_oe), 0);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                     input logic [NB-1:0] b0, input logic [NB-1:0] b1, input bit intrude);
      @(negedge clk); ld_n = 1'b0; rw = 1'b0; addr = AW'(a);
      @(negedge clk); ld_n = 1'b1; rw = 1'b1; addr = AW'(~a);
      chk_oe_off("R8");
      @(negedge clk); din = w0; bwe_n = b0;
      if (intrude) begin ld_n = 1'b0; rw = 1'b1; addr = AW'(a ^ 1); end
      chk_oe_off("R8");
      @(negedge clk); ld_n = 1'b1; din = w1; bwe_n = b1;
      chk_oe_off("R8");
      mn[2*a]   = mrg(mn[2*a],   w0, b0);
      mn[2*a+1] = mrg(mn[2*a+1], w1, b1);
      mw[a]     = mrg(mw[a],     w0, b0);
      mw[a^1]   = mrg(mw[a^1],   w1, b1);
   endtask

   task automatic rd(input int a);
      logic [DW-1:0] n0, n1, x0, x1;
      n0 = mn[2*a]; n1 = mn[2*a+1]; x0 = mw[a]; x1 = mw[a^1];
      @(negedge clk); ld_n = 1'b0; rw = 1'b1; addr = AW'(a); bwe_n = '1;
      @(negedge clk); ld_n = 1'b1;
      @(negedge clk); chk_oe_off("R8");
      @(negedge clk);
      if (!dll_en) begin
         chk(n_oe && w_oe, "R6", DW'({n_oe, w_oe}), 3);
         chk(n_dq == n0, "R4", n_dq, n0);
         chk(w_dq == x0, "R5", w_dq, x0);
         chk(n_cq && !n_cqn && w_cq, "R9", DW'({n_cq, n_cqn, w_cq}), 5);
      end else begin
         chk_oe_off("R7");
      end
      @(negedge clk);
      if (!dll_en) begin
         chk(n_oe && w_oe, "R6", DW'({n_oe, w_oe}), 3);
         chk(n_dq == n1, "R4", n_dq, n1);
         chk(w_dq == x1, "R5", w_dq, x1);
      end else begin
         chk(n_oe && w_oe, "R7", DW'({n_oe, w_oe}), 3);
         chk(n_dq == n0, "R4", n_dq, n0);
         chk(w_dq == x0, "R5", w_dq, x0);
         chk(n_cqn && !n_cq && w_cqn, "R9", DW'({n_cqn, n_cq, w_cqn}), 5);
      end
      @(negedge clk);
      if (!dll_en) begin
         chk_oe_off("R6");
      end else begin
         chk(n_oe && w_oe, "R7", DW'({n_oe, w_oe}), 3);
         chk(n_dq == n1, "R4", n_dq, n1);
         chk(w_dq == x1, "R5", w_dq, x1);
      end
      @(negedge clk); chk_oe_off("R8");
      @(negedge clk);
   endtask

   task automatic idle4(input string req);
      repeat (4) begin
         @(negedge clk);
         chk_oe_off(req);
      end
   endtask

   task automatic nop_run();
      @(negedge clk); ld_n = 1'b1; rw = 1'b0; addr = AW'(5); din = 16'hDEAD; bwe_n = '0;
      @(negedge clk); ld_n = 1'b0; rw = 1'b1; chk_oe_off("R1");
      @(negedge clk); ld_n = 1'b1; rw = 1'b0; chk_oe_off("R1");
      @(negedge clk); ld_n = 1'b0; rw = 1'b0; chk_oe_off("R1");
      @(negedge clk); ld_n = 1'b1; rw = 1'b1; chk_oe_off("R1");
      @(negedge clk); chk_oe_off("R1");
      @(negedge clk); chk_oe_off("R1");
      @(negedge clk); chk_oe_off("R1"); bwe_n = '1;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) mn[i] = '0;
      for (int i = 0; i < 8; i++)  mw[i] = '0;
      rst_n = 1'b0; ld_n = 1'b1; rw = 1'b0; addr = '0; dll_en = 1'b0; din = '0; bwe_n = '1;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk_oe_off("R10");
      chk(!n_cq && n_cqn && !w_cq && w_cqn, "R10", DW'({n_cq, n_cqn, w_cq, w_cqn}), 5);
      rst_n = 1'b1;
      @(negedge clk);
      chk(n_cq && !n_cqn, "R9", DW'({n_cq, n_cqn}), 2);

      // full writes over every address (R2), then reads in both modes
      for (int a = 0; a < 8; a++) wr(a, pat(a, 0, 0), pat(a, 1, 0), '0, '0, 1'b0);
      for (int a = 0; a < 8; a++) rd(a);
      dll_en = 1'b1;
      for (int a = 0; a < 8; a++) rd(a);

      // byte-masked writes, R3
      dll_en = 1'b0;
      for (int a = 0; a < 8; a++)
         wr(a, pat(a, 0, 1), pat(a, 1, 1), NB'(a), NB'(a >> 1), 1'b0);
      for (int a = 7; a >= 0; a--) rd(a);
      dll_en = 1'b1;
      for (int a = 0; a < 8; a++)
         wr(a, pat(a, 2, 2), pat(a, 3, 2), NB'(3 - (a % 4)), NB'(a % 3), 1'b0);
      for (int a = 0; a < 8; a++) rd(a);

      // strobe on the ignored main rise inside a write, R1
      dll_en = 1'b0;
      wr(2, 16'h1234, 16'h5678, '0, '0, 1'b1);
      idle4("R1");
      dll_en = 1'b1;
      wr(5, 16'h9ABC, 16'hDEF0, '0, '0, 1'b1);
      idle4("R1");
      rd(2); rd(5); rd(3); rd(4);

      // no-op slots and phase-1 strobes leave memory alone, R1
      nop_run();
      dll_en = 1'b0;
      for (int a = 0; a < 8; a++) rd(a);

      // reset during a read, R10
      @(negedge clk); ld_n = 1'b0; rw = 1'b1; addr = AW'(3);
      @(negedge clk); ld_n = 1'b1; rst_n = 1'b0;
      repeat (4) begin
         @(negedge clk);
         chk_oe_off("R10");
         chk(!n_cq && n_cqn, "R10", DW'({n_cq, n_cqn}), 1);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(n_cq && w_cq, "R9", DW'({n_cq, w_cq}), 3);
      rd(3); rd(6);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule